// File: doc/BRIEF.md
# Dual-Channel Request-to-Send Controller

This block owns the request-to-send bit of each serial channel and drives the matching active-low output pin. Software changes a bit in two ways. It can write a one-hot mask to a pair of output-port registers, one of which raises bits and the other lowers them. It can also issue an assert or negate command through the channel's command strobe. The receive and transmit paths can change the bit as well when the host enables automatic flow control for that channel.

With receive control on, the bit tracks edges of the receiver FIFO full flag. When the FIFO becomes full, the far end is told to stop. When it drains from full, the far end may send again. With transmit control on, the bit drops once the final character has left the line, stop bits included.

Every source is reduced to a per-channel set request and a per-channel clear request. These are resolved in one register per channel. A clear beats a set, and the bit holds when no source is active. The channel count, the bus widths and the two register offsets are parameters.

Top module: `rts_flow_ctrl`

## Requirements
- R1: Output `rts_n[i]` is low exactly when channel i's request bit is set, and high when it is clear. A change appears one clock after the cycle that causes it.
- R2: A write to offset SET_OFS (default 0x1E) with a one in `wr_data[i]` sets channel i. Zero bits leave their channels unchanged.
- R3: A write to offset CLR_OFS (default 0x1F) with a one in `wr_data[i]` clears channel i. Zero bits leave their channels unchanged.
- R4: When `cmd_stb[i]` is high, `cmd_code[2i+1:2i]` = 2'b01 sets channel i and 2'b10 clears it. Codes 2'b00 and 2'b11 have no effect, and no code has any effect while the strobe is low.
- R5: With `rx_ctl_en[i]` high, a 0-to-1 change of `rx_full[i]` clears channel i and a 1-to-0 change sets it. A steady level of `rx_full[i]` has no effect. With `rx_ctl_en[i]` low, the flag has no effect.
- R6: With `tx_ctl_en[i]` high, a `tx_last_done[i]` pulse clears channel i. With `tx_ctl_en[i]` low, the pulse has no effect.
- R7: While `rst_n` is low, every request bit is cleared and every `rts_n` is high.
- R8: If a set source and a clear source hit the same channel in the same cycle, the channel ends up cleared.
- R9: With no set or clear source active, a channel holds its value. Writes to any other offset do not change it.
- R10: Bit 0 of the write data, command lane 0 and the per-channel inputs at index 0 belong to channel A. Index 1 belongs to channel B, and the two channels do not affect each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of the serial block |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| wr_addr | input | ADDR_W | Register byte offset |
| wr_data | input | DATA_W | Write data, bit i selects channel i |
| cmd_stb | input | NCH | Per-channel command strobe |
| cmd_code | input | 2*NCH | Per-channel command code, lane i at bits 2i+1:2i |
| rx_full | input | NCH | Receiver FIFO full level per channel |
| tx_last_done | input | NCH | Pulse when the last character, stop bits included, is sent |
| rx_ctl_en | input | NCH | Mode bit enabling receive flow control |
| tx_ctl_en | input | NCH | Mode bit enabling transmit flow control |
| rts_n | output | NCH | Active-low request-to-send pins |

## Verification
The cases hardest to reach from the ports are the edge-only behaviour of receive control and same-cycle conflicts. A full flag that is held high must be shown to have no effect, so the bench first lets the rising edge clear the bit. It then sets the bit by register write while the flag is still high and confirms over several idle cycles that the bit stays set. Conflicts are produced by placing a set source and a clear source of different kinds on the same clock: a register set with a negate command, an assert command with a transmit-done pulse, and a receive falling edge with a clear-register write.

// File: rtl/rts_pkg.sv
package rts_pkg;

   typedef enum logic [1:0] {
      RTS_CMD_NOP    = 2'b00,
      RTS_CMD_ASSERT = 2'b01,
      RTS_CMD_NEGATE = 2'b10,
      RTS_CMD_RSVD   = 2'b11
   } rts_cmd_e;

   localparam int unsigned RTS_CMD_W = 2;

endpackage

// File: rtl/rts_wr_decode.sv
module rts_wr_decode #(
   parameter int unsigned          ADDR_W  = 8,
   parameter int unsigned          DATA_W  = 8,
   parameter int unsigned          NCH     = 2,
   parameter logic [ADDR_W-1:0]    SET_OFS = 'h1E,
   parameter logic [ADDR_W-1:0]    CLR_OFS = 'h1F
) (
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   output logic [NCH-1:0]    wr_set,
   output logic [NCH-1:0]    wr_clr
);

   logic hit_set;
   logic hit_clr;
   logic unused_data;

   assign hit_set     = wr_en && (wr_addr == SET_OFS);
   assign hit_clr     = wr_en && (wr_addr == CLR_OFS);
   assign unused_data = ^wr_data;

   always_comb begin
      wr_set = '0;
      wr_clr = '0;
      for (int i = 0; i < int'(NCH); i++) begin
         wr_set[i] = hit_set && wr_data[i];
         wr_clr[i] = hit_clr && wr_data[i];
      end
   end

endmodule

// File: rtl/rts_edge_det.sv
module rts_edge_det (
   input  logic clk,
   input  logic rst_n,
   input  logic lvl,
   output logic rise,
   output logic fall
);

   logic lvl_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lvl_q <= 1'b0;
      else        lvl_q <= lvl;
   end

   assign rise = lvl && !lvl_q;
   assign fall = !lvl && lvl_q;

endmodule

// File: rtl/rts_bit_cell.sv
module rts_bit_cell (
   input  logic clk,
   input  logic rst_n,
   input  logic set_req,
   input  logic clr_req,
   output logic q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       q <= 1'b0;
      else if (clr_req) q <= 1'b0;
      else if (set_req) q <= 1'b1;
   end

endmodule

// File: rtl/rts_flow_ctrl.sv
module rts_flow_ctrl #(
   parameter int unsigned          NCH     = 2,
   parameter int unsigned          ADDR_W  = 8,
   parameter int unsigned          DATA_W  = 8,
   parameter logic [ADDR_W-1:0]    SET_OFS = 'h1E,
   parameter logic [ADDR_W-1:0]    CLR_OFS = 'h1F
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           wr_en,
   input  logic [ADDR_W-1:0]              wr_addr,
   input  logic [DATA_W-1:0]              wr_data,
   input  logic [NCH-1:0]                 cmd_stb,
   input  logic [NCH*rts_pkg::RTS_CMD_W-1:0] cmd_code,
   input  logic [NCH-1:0]                 rx_full,
   input  logic [NCH-1:0]                 tx_last_done,
   input  logic [NCH-1:0]                 rx_ctl_en,
   input  logic [NCH-1:0]                 tx_ctl_en,
   output logic [NCH-1:0]                 rts_n
);
   import rts_pkg::*;

   localparam int unsigned CW = RTS_CMD_W;

   generate
      if (NCH < 1)       begin : g_bad_nch  $error("NCH must be at least 1"); end
      if (NCH > DATA_W)  begin : g_bad_dw   $error("DATA_W must cover one bit per channel"); end
      if (SET_OFS == CLR_OFS) begin : g_bad_ofs $error("SET_OFS and CLR_OFS must differ"); end
   endgenerate

   logic [NCH-1:0] wr_set;
   logic [NCH-1:0] wr_clr;
   logic [NCH-1:0] rts_q;

   rts_wr_decode #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W),
      .NCH    (NCH),
      .SET_OFS(SET_OFS),
      .CLR_OFS(CLR_OFS)
   ) u_dec (
      .wr_en  (wr_en),
      .wr_addr(wr_addr),
      .wr_data(wr_data),
      .wr_set (wr_set),
      .wr_clr (wr_clr)
   );

   for (genvar g = 0; g < NCH; g++) begin : g_ch
      rts_cmd_e cmd;
      logic     rx_rise;
      logic     rx_fall;
      logic     set_any;
      logic     clr_any;

      assign cmd = rts_cmd_e'(cmd_code[g*CW +: CW]);

      rts_edge_det u_rx_edge (
         .clk  (clk),
         .rst_n(rst_n),
         .lvl  (rx_full[g]),
         .rise (rx_rise),
         .fall (rx_fall)
      );

      assign set_any = wr_set[g]
                     | (cmd_stb[g] && cmd == RTS_CMD_ASSERT)
                     | (rx_ctl_en[g] && rx_fall);

      assign clr_any = wr_clr[g]
                     | (cmd_stb[g] && cmd == RTS_CMD_NEGATE)
                     | (rx_ctl_en[g] && rx_rise)
                     | (tx_ctl_en[g] && tx_last_done[g]);

      rts_bit_cell u_cell (
         .clk    (clk),
         .rst_n  (rst_n),
         .set_req(set_any),
         .clr_req(clr_any),
         .q      (rts_q[g])
      );

      assign rts_n[g] = ~rts_q[g];
   end

endmodule

// File: rtl/rts_flow_ctrl_chk.sv
module rts_flow_ctrl_chk #(
   parameter int unsigned          NCH     = 2,
   parameter int unsigned          ADDR_W  = 8,
   parameter int unsigned          DATA_W  = 8,
   parameter logic [ADDR_W-1:0]    SET_OFS = 'h1E,
   parameter logic [ADDR_W-1:0]    CLR_OFS = 'h1F
) (
   input logic                clk,
   input logic                rst_n,
   input logic                wr_en,
   input logic [ADDR_W-1:0]   wr_addr,
   input logic [DATA_W-1:0]   wr_data,
   input logic [NCH-1:0]      cmd_stb,
   input logic [NCH*2-1:0]    cmd_code,
   input logic [NCH-1:0]      rx_full,
   input logic [NCH-1:0]      tx_last_done,
   input logic [NCH-1:0]      rx_ctl_en,
   input logic [NCH-1:0]      tx_ctl_en,
   input logic [NCH-1:0]      rts_n
);

   logic [NCH-1:0] rx_seen;
   logic [NCH-1:0] set_ev;
   logic [NCH-1:0] clr_ev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rx_seen <= '0;
      else        rx_seen <= rx_full;
   end

   always_comb begin
      for (int i = 0; i < int'(NCH); i++) begin
         set_ev[i] = (wr_en && wr_addr == SET_OFS && wr_data[i])
                  || (cmd_stb[i] && cmd_code[2*i +: 2] == 2'b01)
                  || (rx_ctl_en[i] && !rx_full[i] && rx_seen[i]);
         clr_ev[i] = (wr_en && wr_addr == CLR_OFS && wr_data[i])
                  || (cmd_stb[i] && cmd_code[2*i +: 2] == 2'b10)
                  || (rx_ctl_en[i] && rx_full[i] && !rx_seen[i])
                  || (tx_ctl_en[i] && tx_last_done[i]);
      end
   end

   assert_reset_high_R7: assert property (@(posedge clk) !rst_n |=> &rts_n);

   for (genvar g = 0; g < NCH; g++) begin : g_prop
      assert_clear_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
         clr_ev[g] |=> rts_n[g]);
      assert_set_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
         (set_ev[g] && !clr_ev[g]) |=> !rts_n[g]);
      assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
         (!set_ev[g] && !clr_ev[g]) |=> $stable(rts_n[g]));
      assert_tx_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
         (tx_ctl_en[g] && tx_last_done[g]) |=> rts_n[g]);
   end

endmodule

bind rts_flow_ctrl rts_flow_ctrl_chk #(
   .NCH(NCH), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SET_OFS(SET_OFS), .CLR_OFS(CLR_OFS)
) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
   .cmd_stb(cmd_stb), .cmd_code(cmd_code), .rx_full(rx_full),
   .tx_last_done(tx_last_done), .rx_ctl_en(rx_ctl_en), .tx_ctl_en(tx_ctl_en),
   .rts_n(rts_n)
);

// File: tb/rts_flow_ctrl_bench.sv
module rts_flow_ctrl_bench;

   localparam logic [7:0] SET_A = 8'h1E;
   localparam logic [7:0] CLR_A = 8'h1F;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       wr_en;
   logic [7:0] wr_addr;
   logic [7:0] wr_data;
   logic [1:0] cmd_stb;
   logic [3:0] cmd_code;
   logic [1:0] rx_full;
   logic [1:0] tx_last_done;
   logic [1:0] rx_ctl_en;
   logic [1:0] tx_ctl_en;
   logic [1:0] rts_n;

   int n_chk  = 0;
   int n_fail = 0;

   always #2 clk = ~clk;

   rts_flow_ctrl u_rts_flow_ctrl (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .cmd_stb(cmd_stb), .cmd_code(cmd_code), .rx_full(rx_full),
      .tx_last_done(tx_last_done), .rx_ctl_en(rx_ctl_en), .tx_ctl_en(tx_ctl_en),
      .rts_n(rts_n)
   );

   task automatic check(input string req, input logic [1:0] exp);
      n_chk++;
      if (rts_n !== exp) begin
         n_fail++;
         $display("FAIL %s: rts_n=%b expected %b", req, rts_n, exp);
      end
   endtask

   // one clock: inputs already driven at a negedge; strobes dropped afterwards
   task automatic step();
      @(posedge clk);
      @(negedge clk);
      wr_en = 1'b0; cmd_stb = '0; tx_last_done = '0;
   endtask

   task automatic wr(input logic [7:0] a, input logic [7:0] d);
      wr_en = 1'b1; wr_addr = a; wr_data = d; step();
   endtask

   task automatic cmd(input int ch, input logic [1:0] c, input logic stb);
      cmd_stb[ch] = stb; cmd_code[2*ch +: 2] = c; step();
   endtask

   task automatic t_reset();
      check("R7 reset state", 2'b11);
   endtask

   task automatic t_set_reg();
      wr(SET_A, 8'h01); check("R2 R10 set A", 2'b10);
      wr(SET_A, 8'h00); check("R2 zero bits ignored", 2'b10);
      wr(SET_A, 8'h02); check("R2 R1 set B", 2'b00);
   endtask

   task automatic t_clr_reg();
      wr(CLR_A, 8'h01); check("R3 clear A", 2'b01);
      wr(CLR_A, 8'h00); check("R3 zero bits ignored", 2'b01);
      wr(CLR_A, 8'h02); check("R3 clear B", 2'b11);
   endtask

   task automatic t_other_addr();
      wr(8'h20, 8'hFF); check("R9 other offset ignored", 2'b11);
      wr(SET_A, 8'h03);
      wr(8'h1D, 8'hFF); check("R9 other offset keeps set", 2'b00);
      repeat (3) step();
      check("R9 hold idle", 2'b00);
      wr(CLR_A, 8'h03);
   endtask

   task automatic t_cmd();
      cmd(1, 2'b01, 1'b1); check("R4 assert B", 2'b01);
      cmd(1, 2'b11, 1'b1); check("R4 reserved code", 2'b01);
      cmd(1, 2'b00, 1'b1); check("R4 nop code", 2'b01);
      cmd(1, 2'b10, 1'b1); check("R4 negate B", 2'b11);
      cmd(0, 2'b01, 1'b0); check("R4 no strobe", 2'b11);
      cmd(0, 2'b01, 1'b1); check("R4 R10 assert A", 2'b10);
      cmd(0, 2'b10, 1'b1); check("R4 negate A", 2'b11);
   endtask

   task automatic t_rx_auto();
      rx_ctl_en = 2'b01;
      wr(SET_A, 8'h03);
      rx_full[0] = 1'b1; step(); check("R5 full rise clears A", 2'b01);
      wr(SET_A, 8'h01);
      repeat (4) step();
      check("R5 static full no effect", 2'b00);
      wr(CLR_A, 8'h01);
      rx_full[0] = 1'b0; step(); check("R5 full fall sets A", 2'b00);
      rx_full[1] = 1'b1; step(); check("R5 disabled B rise", 2'b00);
      rx_full[1] = 1'b0; step(); check("R5 disabled B fall", 2'b00);
      wr(CLR_A, 8'h03);
      rx_full[1] = 1'b1; step();
      rx_full[1] = 1'b0; step(); check("R5 disabled B fall keeps clear", 2'b11);
      rx_ctl_en = 2'b00;
   endtask

   task automatic t_tx_auto();
      tx_ctl_en = 2'b01;
      wr(SET_A, 8'h03);
      tx_last_done = 2'b01; step(); check("R6 tx done clears A", 2'b01);
      tx_last_done = 2'b10; step(); check("R6 disabled B ignores", 2'b01);
      wr(CLR_A, 8'h02);
   endtask

   task automatic t_priority();
      wr_en = 1'b1; wr_addr = SET_A; wr_data = 8'h01;
      cmd_stb[0] = 1'b1; cmd_code[1:0] = 2'b10;
      step(); check("R8 set write vs negate", 2'b11);
      cmd_stb[0] = 1'b1; cmd_code[1:0] = 2'b01; tx_last_done = 2'b01;
      step(); check("R8 assert vs tx done", 2'b11);
      rx_ctl_en = 2'b01; rx_full[0] = 1'b1; step();
      rx_full[0] = 1'b0; wr_en = 1'b1; wr_addr = CLR_A; wr_data = 8'h01;
      step(); check("R8 rx fall vs clear write", 2'b11);
      rx_ctl_en = 2'b00; tx_ctl_en = 2'b00;
   endtask

   task automatic t_reset_mid();
      wr(SET_A, 8'h03); check("R1 both set", 2'b00);
      rst_n = 1'b0; #1; check("R7 reset mid-run", 2'b11);
      @(negedge clk); rst_n = 1'b1; step();
      check("R7 after reset release", 2'b11);
   endtask

   initial begin
      rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
      cmd_stb = '0; cmd_code = '0; rx_full = '0; tx_last_done = '0;
      rx_ctl_en = '0; tx_ctl_en = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      step();
      t_reset();
      t_set_reg();
      t_clr_reg();
      t_other_addr();
      t_cmd();
      t_rx_auto();
      t_tx_auto();
      t_priority();
      t_reset_mid();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      #400000;
      n_chk++; n_fail++;
      $display("FAIL watchdog: run did not finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule